// File: doc/BRIEF.md
# Slope-Compensated Peak-Current Switch Controller

This block drives the reference code of an external DAC that feeds a current-sense comparator. It also produces the gated drive for the power switch. Each switching period starts on a strobe from one of twelve PWM period generators, chosen by a select field. At that point the controller reloads the DAC code with a programmed start value and raises the switch drive.

For the rest of the period the DAC code moves away from the start value as a compensation ramp. It rises or falls, and its total excursion per period is set by an 8-bit rate. The rate is spread over the programmed period length by a fixed-point accumulator with 8 fractional bits. The ramp clamps at full scale or at zero and never wraps. Clearing the slope enable holds the code flat at the start value.

The comparator trip is asynchronous and is first brought into the clock domain by two flops. After a programmable blanking window following each period start, a trip ends the on-pulse for the remainder of the period. A maximum on-time counter ends the pulse when no trip arrives. A strobe that arrives during an active on-pulse is ignored. A low-frequency dimming input gates the final drive output.

Top module: `slope_pcmc`

## Requirements
- R1: While reset is asserted and after its release, before any cycle start, `drive` is 0 and `dac_code` equals `cfg_start`.
- R2: A cycle starts only at a clock edge where `sync_strobe[cfg_src_sel]` is 1 and the internal on-pulse is inactive. Values of `cfg_src_sel` of 12 and above select no source. After the start edge, `drive` is 1 (with `dim_gate` high) and `dac_code` equals `cfg_start`.
- R3: With `cfg_slope_en`=1 and `cfg_falling`=0, n clock edges after the start edge, `dac_code` = min(`cfg_start` + floor(n·S/256), 4095). Here S = floor(`cfg_rate`·256 / P), and P is `cfg_period`, with 0 treated as 1.
- R4: With `cfg_slope_en`=1 and `cfg_falling`=1, `dac_code` = max(`cfg_start` − floor(n·S/256), 0), using the same S and n as R3.
- R5: With `cfg_slope_en`=0, `dac_code` equals `cfg_start` at all times.
- R6: A trip raised between edges j−1 and j reaches the pulse logic through two synchronising flops. It ends the on-pulse at edge j+2, once blanking has elapsed. `drive` then stays 0 until the next cycle start.
- R7: A cycle start with `cfg_blank`=B ignores trips at edges 1 to B after the start edge. The earliest trip-driven fall is therefore at edge B+1.
- R8: With no trip, the on-pulse ends at edge max(`cfg_max_on`,1) after the start edge.
- R9: A selected strobe that arrives while the on-pulse is active does not restart the ramp and does not lower `drive`. A strobe that arrives after the pulse has ended starts a fresh cycle.
- R10: `drive` is 0 whenever `dim_gate` is 0. When `dim_gate` returns to 1 during an active on-pulse, `drive` follows the pulse again. `dac_code` is not affected by `dim_gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_strobe | input | 12 | Period-start strobes, one per PWM generator |
| trip_async | input | 1 | Asynchronous comparator trip |
| dim_gate | input | 1 | Low-frequency dimming gate for the drive |
| cfg_slope_en | input | 1 | Ramp enable |
| cfg_falling | input | 1 | Ramp direction, 1 = falling |
| cfg_src_sel | input | 4 | Index of the strobe that starts a cycle |
| cfg_start | input | 12 | Ramp start code |
| cfg_rate | input | 8 | Total ramp excursion per period, in DAC codes |
| cfg_period | input | 16 | Period length in clocks |
| cfg_blank | input | 8 | Trip blanking window in clocks |
| cfg_max_on | input | 16 | Maximum on-time in clocks |
| dac_code | output | 12 | Compensation ramp code for the DAC |
| drive | output | 1 | Gated switch drive |

## Verification
The bench builds the block with its defaults: 12 sources, a 12-bit code, an 8-bit rate with 8 fractional accumulator bits, a 16-bit period and an 8-bit blanking count. Short random periods make the per-clock step large, so 40-cycle windows drive the ramp into both clamps. The 8-bit blanking range lets random trials cross all three drive-ending orders: trip before blanking ends, trip after it, and the on-time limit first. The unused select values 12 to 15 are reached directly by the 4-bit select field.

// File: rtl/slope_pcmc_pkg.sv
package slope_pcmc_pkg;
  typedef enum logic {
    RAMP_UP   = 1'b0,
    RAMP_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/pcmc_sync2.sv
module pcmc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pcmc_ramp.sv
module pcmc_ramp
  import slope_pcmc_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int RATE_W = 8,
  parameter int FRAC_W = 8,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              slope_en,
  input  ramp_dir_e         dir,
  input  logic [CODE_W-1:0] start_code,
  input  logic [RATE_W-1:0] rate,
  input  logic [PER_W-1:0]  period,
  output logic [CODE_W-1:0] code
);
  localparam int ACC_W  = CODE_W + FRAC_W;
  localparam int STEP_W = RATE_W + FRAC_W;
  localparam int QW     = (STEP_W > PER_W) ? STEP_W : PER_W;
  localparam logic [ACC_W-1:0] CAP = {{CODE_W{1'b1}}, {FRAC_W{1'b0}}};

  // per-clock increment: rate spread over the period, FRAC_W fraction bits
  function automatic logic [STEP_W-1:0] step_of(input logic [RATE_W-1:0] r,
                                                 input logic [PER_W-1:0]  p);
    logic [QW-1:0] num, den, quo;
    num = QW'({r, {FRAC_W{1'b0}}});
    den = (p == '0) ? QW'(1) : QW'(p);
    quo = num / den;
    return quo[STEP_W-1:0];
  endfunction

  // start value offset in the chosen direction, clamped at the rails
  function automatic logic [CODE_W-1:0] code_of(input logic [CODE_W-1:0] s,
                                                 input logic [CODE_W-1:0] off,
                                                 input logic              en,
                                                 input ramp_dir_e         d);
    logic [CODE_W:0] sum;
    if (!en) return s;
    if (d == RAMP_UP) begin
      sum = {1'b0, s} + {1'b0, off};
      return sum[CODE_W] ? {CODE_W{1'b1}} : sum[CODE_W-1:0];
    end
    return (off > s) ? '0 : (s - off);
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;
  logic [ACC_W-1:0] acc_next;

  always_comb begin
    acc_sum  = {1'b0, acc_q} + (ACC_W + 1)'(step_of(rate, period));
    acc_next = (acc_sum > {1'b0, CAP}) ? CAP : acc_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (restart) acc_q <= '0;
    else              acc_q <= acc_next;
  end

  assign code = code_of(start_code, acc_q[ACC_W-1:FRAC_W], slope_en, dir);
endmodule

// File: rtl/pcmc_pulse.sv
module pcmc_pulse #(
  parameter int BLANK_W = 8,
  parameter int ON_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_start,
  input  logic               trip_sync,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic [ON_W-1:0]    max_on,
  output logic               drive_on,
  output logic               blank_active,
  output logic               trip_ok,
  output logic               max_hit
);
  logic [BLANK_W-1:0] blank_q;
  logic [ON_W-1:0]    on_q;

  assign blank_active = (blank_q != '0);
  assign trip_ok      = drive_on && !blank_active && trip_sync;
  assign max_hit      = drive_on && (({1'b0, on_q} + 1'b1) >= {1'b0, max_on});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_on <= 1'b0;
      blank_q  <= '0;
      on_q     <= '0;
    end else if (cycle_start) begin
      drive_on <= 1'b1;
      blank_q  <= blank_len;
      on_q     <= '0;
    end else begin
      if (blank_active) blank_q <= blank_q - 1'b1;
      if (drive_on) begin
        if (trip_ok || max_hit) drive_on <= 1'b0;
        else                    on_q     <= on_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slope_pcmc.sv
module slope_pcmc
  import slope_pcmc_pkg::*;
#(
  parameter int N_SRC   = 12,
  parameter int CODE_W  = 12,
  parameter int RATE_W  = 8,
  parameter int FRAC_W  = 8,
  parameter int PER_W   = 16,
  parameter int BLANK_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   sync_strobe,
  input  logic               trip_async,
  input  logic               dim_gate,
  input  logic               cfg_slope_en,
  input  logic               cfg_falling,
  input  logic [SEL_W-1:0]   cfg_src_sel,
  input  logic [CODE_W-1:0]  cfg_start,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic [PER_W-1:0]   cfg_max_on,
  output logic [CODE_W-1:0]  dac_code,
  output logic               drive
);
  logic src_hit, cycle_start, trip_sync;
  logic drive_on, blank_active, trip_ok, max_hit;
  logic [N_SRC-1:0] sel_hits;

  // one decoder leg per source; out-of-range selects match none
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign sel_hits[i] = sync_strobe[i] && (cfg_src_sel == SEL_W'(i));
  end

  assign src_hit     = |sel_hits;
  assign cycle_start = src_hit && !drive_on;

  pcmc_sync2 u_trip_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (trip_async),
    .q_sync  (trip_sync)
  );

  pcmc_ramp #(
    .CODE_W (CODE_W),
    .RATE_W (RATE_W),
    .FRAC_W (FRAC_W),
    .PER_W  (PER_W)
  ) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (cycle_start),
    .slope_en   (cfg_slope_en),
    .dir        (cfg_falling ? RAMP_DOWN : RAMP_UP),
    .start_code (cfg_start),
    .rate       (cfg_rate),
    .period     (cfg_period),
    .code       (dac_code)
  );

  pcmc_pulse #(
    .BLANK_W (BLANK_W),
    .ON_W    (PER_W)
  ) u_pulse (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_start  (cycle_start),
    .trip_sync    (trip_sync),
    .blank_len    (cfg_blank),
    .max_on       (cfg_max_on),
    .drive_on     (drive_on),
    .blank_active (blank_active),
    .trip_ok      (trip_ok),
    .max_hit      (max_hit)
  );

  assign drive = drive_on && dim_gate;
endmodule

// File: rtl/slope_pcmc_checker.sv
module slope_pcmc_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_hit,
  input logic              cycle_start,
  input logic              drive_on,
  input logic              trip_ok,
  input logic              max_hit,
  input logic              blank_active,
  input logic              dim_gate,
  input logic              drive,
  input logic              cfg_slope_en,
  input logic              cfg_falling,
  input logic [CODE_W-1:0] cfg_start,
  input logic [CODE_W-1:0] dac_code
);
  a_r2_start_raises_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> drive_on);

  a_r9_busy_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (src_hit && drive_on && !trip_ok && !max_hit) |=> drive_on);

  a_r6_trip_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ok |=> !drive_on);

  a_r7_blank_holds_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_active && drive_on && !max_hit) |=> drive_on);

  a_r10_dim_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_gate |-> !drive);

  a_r5_flat_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_slope_en |-> (dac_code == cfg_start));

  a_r3_rising_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_start && cfg_slope_en && !cfg_falling) |=>
      (!$stable(cfg_start) || !cfg_slope_en || cfg_falling || (dac_code >= $past(dac_code))));

  a_r4_falling_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_start && cfg_slope_en && cfg_falling) |=>
      (!$stable(cfg_start) || !cfg_slope_en || !cfg_falling || (dac_code <= $past(dac_code))));
endmodule

bind slope_pcmc slope_pcmc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_hit      (src_hit),
  .cycle_start  (cycle_start),
  .drive_on     (drive_on),
  .trip_ok      (trip_ok),
  .max_hit      (max_hit),
  .blank_active (blank_active),
  .dim_gate     (dim_gate),
  .drive        (drive),
  .cfg_slope_en (cfg_slope_en),
  .cfg_falling  (cfg_falling),
  .cfg_start    (cfg_start),
  .dac_code     (dac_code)
);

// File: tb/slope_pcmc_bench.sv
module slope_pcmc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sync_strobe = '0;
  logic        trip_async = 1'b0;
  logic        dim_gate = 1'b1;
  logic        cfg_slope_en = 1'b1;
  logic        cfg_falling = 1'b0;
  logic [3:0]  cfg_src_sel = 4'd0;
  logic [11:0] cfg_start = 12'd777;
  logic [7:0]  cfg_rate = 8'd0;
  logic [15:0] cfg_period = 16'd100;
  logic [7:0]  cfg_blank = 8'd0;
  logic [15:0] cfg_max_on = 16'd5;
  logic [11:0] dac_code;
  logic        drive;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slope_pcmc u_slope_pcmc (
    .clk(clk), .rst_n(rst_n), .sync_strobe(sync_strobe), .trip_async(trip_async),
    .dim_gate(dim_gate), .cfg_slope_en(cfg_slope_en), .cfg_falling(cfg_falling),
    .cfg_src_sel(cfg_src_sel), .cfg_start(cfg_start), .cfg_rate(cfg_rate),
    .cfg_period(cfg_period), .cfg_blank(cfg_blank), .cfg_max_on(cfg_max_on),
    .dac_code(dac_code), .drive(drive)
  );

  function automatic int exp_code(int start, int rate, int per, bit en, bit fall, int n);
    int step, off;
    if (!en) return start;
    step = (rate * 256) / ((per == 0) ? 1 : per);
    off = (n * step) / 256;
    if (off > 4095) off = 4095;
    if (fall) return (start - off < 0) ? 0 : start - off;
    return (start + off > 4095) ? 4095 : start + off;
  endfunction

  function automatic int exp_fall_edge(int b, int m, int d);
    int t_trip, t_max;
    t_trip = (d + 3 > b + 1) ? d + 3 : b + 1;
    t_max = (m < 1) ? 1 : m;
    return (t_trip < t_max) ? t_trip : t_max;
  endfunction

  task automatic chk(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic fire(logic [11:0] mask);
    sync_strobe = mask;
    @(negedge clk);
    sync_strobe = '0;
  endtask

  task automatic wait_idle();
    trip_async = 1'b0;
    for (int i = 0; i < 400 && u_slope_pcmc.drive === 1'b1; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 reset drive", int'(drive), 0);
    chk("R1 reset dac", int'(dac_code), 777);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle drive", int'(drive), 0);
    chk("R1 idle dac", int'(dac_code), 777);

    // R2: non-selected strobe and out-of-range selects start nothing
    cfg_src_sel = 4'd3;
    fire(12'h010);
    for (int n = 0; n < 3; n++) begin
      chk("R2 wrong source", int'(drive), 0);
      @(negedge clk);
    end
    cfg_src_sel = 4'd13;
    fire(12'hFFF);
    chk("R2 select 13 no start", int'(drive), 0);
    cfg_src_sel = 4'd11;
    cfg_max_on = 16'd4;
    fire(12'h800);
    chk("R2 source 11 drive", int'(drive), 1);
    chk("R2 source 11 dac", int'(dac_code), 777);
    wait_idle();

    // R3/R4/R5 random ramps including saturation
    for (int t = 0; t < 40; t++) begin
      int st, rt, pr, sel;
      bit en, fl;
      st = (t % 8 == 0) ? 4095 - ($urandom % 20) : (t % 8 == 1) ? $urandom % 20 : $urandom % 4096;
      rt = $urandom % 256;
      pr = (t % 10 == 3) ? 0 : 1 + $urandom % 60;
      en = ($urandom % 5) != 0;
      fl = $urandom % 2;
      sel = $urandom % 12;
      cfg_start = 12'(st); cfg_rate = 8'(rt); cfg_period = 16'(pr);
      cfg_slope_en = en; cfg_falling = fl; cfg_src_sel = 4'(sel);
      cfg_max_on = 16'd5; cfg_blank = 8'd0;
      fire(12'(1 << sel));
      for (int n = 0; n < 40; n++) begin
        chk(!en ? "R5 flat" : (fl ? "R4 falling ramp" : "R3 rising ramp"),
            int'(dac_code), exp_code(st, rt, pr, en, fl, n));
        @(negedge clk);
      end
      wait_idle();
    end

    // R6/R7/R8 random trip timing against blanking and max on-time
    cfg_slope_en = 1'b1; cfg_falling = 1'b0; cfg_src_sel = 4'd5;
    for (int t = 0; t < 40; t++) begin
      int b, m, d, tf;
      b = $urandom % 10;
      m = 1 + $urandom % 24;
      d = $urandom % 26;
      tf = exp_fall_edge(b, m, d);
      cfg_blank = 8'(b); cfg_max_on = 16'(m);
      fire(12'h020);
      for (int n = 0; n <= tf + 4; n++) begin
        chk((tf == m && m <= d + 3) ? "R8 max on-time" : (b + 1 > d + 3 ? "R7 blanking" : "R6 trip"),
            int'(drive), (n < tf) ? 1 : 0);
        if (n == d) trip_async = 1'b1;
        @(negedge clk);
      end
      wait_idle();
    end

    // R9: strobe during on-pulse ignored, then fresh start after pulse ends
    cfg_start = 12'd100; cfg_rate = 8'd200; cfg_period = 16'd10;
    cfg_blank = 8'd0; cfg_max_on = 16'd30; cfg_src_sel = 4'd0;
    fire(12'h001);
    repeat (5) @(negedge clk);
    fire(12'h001);
    chk("R9 busy strobe dac", int'(dac_code), exp_code(100, 200, 10, 1, 0, 6));
    chk("R9 busy strobe drive", int'(drive), 1);
    wait_idle();
    chk("R9 pulse ended", int'(drive), 0);
    fire(12'h001);
    chk("R9 fresh start drive", int'(drive), 1);
    chk("R9 fresh start dac", int'(dac_code), 100);

    // R10: dimming gates drive only
    @(negedge clk);
    dim_gate = 1'b0;
    #1;
    chk("R10 dim low drive", int'(drive), 0);
    @(negedge clk);
    chk("R10 dim low dac", int'(dac_code), exp_code(100, 200, 10, 1, 0, 2));
    dim_gate = 1'b1;
    #1;
    chk("R10 dim restored drive", int'(drive), 1);
    wait_idle();
    dim_gate = 1'b0;
    fire(12'h001);
    chk("R10 dimmed start drive", int'(drive), 0);
    dim_gate = 1'b1;
    #1;
    chk("R10 pulse under dim", int'(drive), 1);
    wait_idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule